// File: doc/BRIEF.md
# Line access switch controller

This block is the digital controller for a solid-state subscriber line access switch. That switch has four elements: a tip line-break switch, a ring line-break switch, a ring-return switch and a ring-access switch. The controller reads a mode input, a hold (state latch) input and an open-drain shutdown pin. It selects one of three switch states: Idle/Talk, Power Ringing or All Off. It then drives the four switch enables so that a line-break switch is always opened before the ringing switches close.

Two hysteresis monitors can each force All Off. One watches a sampled die-temperature code and the other a sampled battery-voltage code. The thermal monitor also pulls the shutdown pin low, so that other logic on the same pin sees the fault. Pulling the pin high from outside does not defeat thermal shutdown.

The ring-access element can stop conducting only at a ring-current zero crossing. Its enable is therefore released on a zero-crossing strobe. If no strobe arrives, it is released after a bounded timeout.

Top module: `line_access_ctrl`

## Requirements
- R1: After reset, all four enables are 0, the shutdown pull-down is 0 and the hold latch is open (hold input low behaves as transparent).
- R2: With hold low, shutdown pin high and no fault, mode 0 settles to Idle/Talk: tip and ring line-break enables 1, ring-return and ring-access enables 0 (output vector {tip,ring,ret,acc} = 4'b1100).
- R3: Under the same conditions, mode 1 settles to Power Ringing: line-break enables 0, ring-return and ring-access enables 1 (4'b0011).
- R4: A change of the selected state takes effect in stages. The enables of the state being left (except ring-access) turn off at the first clock edge that samples the change. The new state's enables turn on GAP_CYC edges later, so all of line-break and ring-return are off for GAP_CYC cycles.
- R5: While hold is high, the selected mode is the one sampled in the last cycle that hold was low. Mode changes during hold have no effect on the enables.
- R6: When hold falls, the current mode input is selected again at the first clock edge that samples hold low.
- R7: A low shutdown pin forces All Off for the line-break and ring-return enables at the next clock edge, whatever the hold and mode inputs are.
- R8: A valid temperature code strictly above T_TRIP sets the thermal fault at the next edge. That edge drives the shutdown pull-down output high, and the enables go All Off one edge later. A code equal to T_TRIP does not trip.
- R9: The thermal fault clears only on a valid code strictly below T_REL. Codes between the two thresholds, and codes presented without the valid strobe, leave the fault unchanged. After it clears, the mode state returns through the R4 gap.
- R10: Thermal shutdown still forces All Off when the shutdown pin is held high from outside.
- R11: A valid battery code strictly above V_TRIP (a missing battery reads near 0) forces All Off one edge after the fault is registered. The fault clears only on a valid code strictly below V_REL.
- R12: When Ringing ends, the ring-access enable stays 1 until the first edge at which the zero-crossing strobe is high, or until ACC_TMO edges after the ending edge, whichever comes first. A strobe during Ringing has no effect.
- R13: On the move from Ringing to Idle/Talk, the line-break enables turn on after the R4 gap even if ring-access is still on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 selects Idle/Talk, 1 selects Power Ringing |
| hold_i | input | 1 | State latch: low is transparent, high freezes the selected mode |
| sd_pin_i | input | 1 | Resolved level of the open-drain shutdown pin (high when undriven) |
| sd_pull_o | output | 1 | Pull-down enable for the shutdown pin, high during thermal shutdown |
| temp_code_i | input | TEMP_W | Signed die-temperature code in degrees |
| temp_vld_i | input | 1 | Temperature code strobe |
| vbat_code_i | input | VBAT_W | Signed battery-voltage code in volts |
| vbat_vld_i | input | 1 | Battery code strobe |
| zc_i | input | 1 | Ring-current zero-crossing strobe |
| en_tip_brk_o | output | 1 | Tip line-break switch enable |
| en_ring_brk_o | output | 1 | Ring line-break switch enable |
| en_ret_o | output | 1 | Ring-return switch enable |
| en_acc_o | output | 1 | Ring-access switch enable |

## Verification
A mode, hold or shutdown-pin change is due on the enables at the first edge that samples it. A make is due GAP_CYC edges after that. A temperature or battery strobe shows up one edge later than a mode change, because it first sets the registered fault flag, and the pull-down output follows the strobe at that same first edge. The bench drives inputs on falling edges and samples one nanosecond after the rising edge that the counted latency names. For every timing case it samples both the last cycle before the due edge and the due edge itself, including the ring-access release at GAP_CYC and at ACC_TMO. Settled behaviour is swept over every start state and every combination of mode, hold and shutdown pin, with enough cycles allowed for the gap and the ring-access timeout to pass.

// File: rtl/lac_pkg.sv
package lac_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RING = 2'd2,
        ST_GAP  = 2'd3
    } lac_st_e;
endpackage

// File: rtl/lac_hyst_mon.sv
module lac_hyst_mon #(
    parameter int W    = 10,
    parameter int TRIP = 150,
    parameter int REL  = 138
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] code_i,
    input  logic                vld_i,
    output logic                fault_o
);
    localparam logic signed [W-1:0] TRIP_C = W'(TRIP);
    localparam logic signed [W-1:0] REL_C  = W'(REL);

    logic fault_d, fault_q;

    always_comb begin
        fault_d = fault_q;
        if (vld_i) begin
            if (code_i > TRIP_C)
                fault_d = 1'b1;
            else if (code_i < REL_C)
                fault_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign fault_o = fault_q;

    // R8 R11
    trip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && code_i > TRIP_C) |=> fault_o);
    // R9 R11
    rel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && code_i < REL_C) |=> !fault_o);
    // R9
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(fault_o));
endmodule

// File: rtl/lac_mode_sel.sv
module lac_mode_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic hold_i,
    output logic mode_eff_o
);
    logic cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!hold_i) cap_d = mode_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= cap_d;
    end

    assign mode_eff_o = hold_i ? cap_q : mode_i;

    // R5
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |-> $stable(mode_eff_o));
    // R6
    open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |-> (mode_eff_o == mode_i));
endmodule

// File: rtl/lac_seq.sv
module lac_seq
    import lac_pkg::*;
#(
    parameter int GAP_CYC = 4,
    parameter int ACC_TMO = 3125000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  lac_st_e tgt_i,
    input  logic    zc_i,
    output logic    tip_o,
    output logic    ring_o,
    output logic    ret_o,
    output logic    acc_o
);
    localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
    localparam int TW = $clog2(ACC_TMO + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(ACC_TMO);

    typedef struct packed {
        lac_st_e       st;
        lac_st_e       goal;
        logic [CW-1:0] cnt;
        logic          acc;
        logic [TW-1:0] tmo;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.st == ST_GAP) begin
            if (tgt_i == ST_OFF) begin
                seq_d.st = ST_OFF;
            end else if (tgt_i != seq_q.goal) begin
                seq_d.goal = tgt_i;
                seq_d.cnt  = '0;
            end else if (seq_q.cnt == GAP_LAST) begin
                seq_d.st = seq_q.goal;
            end else begin
                seq_d.cnt = seq_q.cnt + CW'(1);
            end
        end else if (tgt_i != seq_q.st) begin
            if (tgt_i == ST_OFF) begin
                seq_d.st = ST_OFF;
            end else begin
                seq_d.st   = ST_GAP;
                seq_d.goal = tgt_i;
                seq_d.cnt  = '0;
            end
        end

        if (seq_d.st == ST_RING) begin
            seq_d.acc = 1'b1;
            seq_d.tmo = '0;
        end else if (seq_q.acc) begin
            if (zc_i || seq_q.tmo == TMO_LAST) begin
                seq_d.acc = 1'b0;
                seq_d.tmo = '0;
            end else begin
                seq_d.tmo = seq_q.tmo + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_OFF;
            seq_q.goal <= ST_OFF;
            seq_q.cnt  <= '0;
            seq_q.acc  <= 1'b0;
            seq_q.tmo  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tip_o  = (seq_q.st == ST_IDLE);
    assign ring_o = (seq_q.st == ST_IDLE);
    assign ret_o  = (seq_q.st == ST_RING);
    assign acc_o  = seq_q.acc;

    // R4
    bbm_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_o) |-> $past(!tip_o));
    // R4
    bbm_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(acc_o) && !$past(ret_o)) |-> $past(!ring_o));
    // R2 R3
    no_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tip_o && ret_o));
    // R12
    acc_zc_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && zc_i && tgt_i != ST_RING && !ret_o) |=> !acc_o);
    // R12
    acc_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.tmo <= TMO_LAST);
endmodule

// File: rtl/line_access_ctrl.sv
module line_access_ctrl
    import lac_pkg::*;
#(
    parameter int TEMP_W  = 10,
    parameter int VBAT_W  = 10,
    parameter int T_TRIP  = 150,
    parameter int T_REL   = 138,
    parameter int V_TRIP  = -10,
    parameter int V_REL   = -15,
    parameter int GAP_CYC = 4,
    parameter int ACC_TMO = 3125000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_i,
    input  logic                     hold_i,
    input  logic                     sd_pin_i,
    output logic                     sd_pull_o,
    input  logic signed [TEMP_W-1:0] temp_code_i,
    input  logic                     temp_vld_i,
    input  logic signed [VBAT_W-1:0] vbat_code_i,
    input  logic                     vbat_vld_i,
    input  logic                     zc_i,
    output logic                     en_tip_brk_o,
    output logic                     en_ring_brk_o,
    output logic                     en_ret_o,
    output logic                     en_acc_o
);
    logic    therm_flt, bat_flt, mode_eff;
    lac_st_e tgt;

    lac_hyst_mon #(.W(TEMP_W), .TRIP(T_TRIP), .REL(T_REL)) therm_mon_i (
        .clk(clk), .rst_n(rst_n), .code_i(temp_code_i),
        .vld_i(temp_vld_i), .fault_o(therm_flt));

    lac_hyst_mon #(.W(VBAT_W), .TRIP(V_TRIP), .REL(V_REL)) bat_mon_i (
        .clk(clk), .rst_n(rst_n), .code_i(vbat_code_i),
        .vld_i(vbat_vld_i), .fault_o(bat_flt));

    lac_mode_sel mode_sel_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hold_i(hold_i),
        .mode_eff_o(mode_eff));

    always_comb begin
        if (!sd_pin_i || therm_flt || bat_flt) tgt = ST_OFF;
        else if (mode_eff)                     tgt = ST_RING;
        else                                   tgt = ST_IDLE;
    end

    lac_seq #(.GAP_CYC(GAP_CYC), .ACC_TMO(ACC_TMO)) seq_i (
        .clk(clk), .rst_n(rst_n), .tgt_i(tgt), .zc_i(zc_i),
        .tip_o(en_tip_brk_o), .ring_o(en_ring_brk_o),
        .ret_o(en_ret_o), .acc_o(en_acc_o));

    assign sd_pull_o = therm_flt;

    // R7
    pin_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_pin_i |=> (!en_tip_brk_o && !en_ring_brk_o && !en_ret_o));
    // R10
    therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_pull_o |=> (!en_tip_brk_o && !en_ret_o));
    // R11
    bat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_flt |=> (!en_ring_brk_o && !en_ret_o));
endmodule

// File: tb/line_access_ctrl_tb_top.sv
module line_access_ctrl_tb_top;
    localparam int GAP = 3;
    localparam int TMO = 10;
    localparam int SETTLE = 20;
    localparam logic [3:0] IDLE = 4'b1100;
    localparam logic [3:0] RING = 4'b0011;
    localparam logic [3:0] OFF  = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, hold = 1'b0, zc = 1'b0;
    logic ext_low = 1'b0, force_hi = 1'b0;
    logic signed [9:0] tcode = 10'sd25, vcode = -10'sd48;
    logic tvld = 1'b0, vvld = 1'b0;
    logic sd_pull, sd_pin, tip, rng, ret, acc;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign sd_pin = force_hi ? 1'b1 : !(ext_low || sd_pull);

    line_access_ctrl #(.GAP_CYC(GAP), .ACC_TMO(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .hold_i(hold),
        .sd_pin_i(sd_pin), .sd_pull_o(sd_pull),
        .temp_code_i(tcode), .temp_vld_i(tvld),
        .vbat_code_i(vcode), .vbat_vld_i(vvld), .zc_i(zc),
        .en_tip_brk_o(tip), .en_ring_brk_o(rng),
        .en_ret_o(ret), .en_acc_o(acc));

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [3:0] exp, logic [3:0] mask);
        logic [3:0] got;
        got = {tip, rng, ret, acc};
        n_chk++;
        if ((got & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s enables got %b expected %b (mask %b)", tag, got, exp, mask);
        end
    endtask

    task automatic chk_pull(string tag, logic exp);
        n_chk++;
        if (sd_pull !== exp) begin
            n_fail++;
            $display("FAIL %s pull-down got %b expected %b", tag, sd_pull, exp);
        end
    endtask

    task automatic temp_strobe(logic signed [9:0] c);
        @(negedge clk); tcode = c; tvld = 1'b1;
        tick(1); tvld = 1'b0;
    endtask

    task automatic vbat_strobe(logic signed [9:0] c);
        @(negedge clk); vcode = c; vvld = 1'b1;
        tick(1); vvld = 1'b0;
    endtask

    task automatic set_mode(logic m);
        @(negedge clk); mode = m;
        tick(1);
    endtask

    initial begin
        repeat (SETTLE * 10000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", OFF, 4'hF);
        chk_pull("R1 reset", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        chk("R1 after release", OFF, 4'hF);
        tick(GAP);
        chk("R2 first idle", IDLE, 4'hF);

        // settled sweep: start state x mode x hold x pin
        for (int s = 0; s < 3; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int x = 0; x < 2; x++) begin
                        logic sm, eff;
                        logic [3:0] exp;
                        sm = (s != 0);
                        @(negedge clk); hold = 1'b0; ext_low = (s == 2); mode = sm;
                        tick(SETTLE);
                        @(negedge clk); mode = m[0]; hold = h[0]; ext_low = x[0];
                        tick(SETTLE);
                        eff = h[0] ? sm : m[0];
                        exp = x[0] ? OFF : (eff ? RING : IDLE);
                        chk($sformatf("R2 R3 R5 R7 sweep s%0d m%0d h%0d x%0d", s, m, h, x), exp, 4'hF);
                    end
                end
            end
        end
        @(negedge clk); hold = 1'b0; ext_low = 1'b0; mode = 1'b0;
        tick(SETTLE);

        // R4 gap idle -> ring
        set_mode(1'b1);
        chk("R4 break edge", OFF, 4'hF);
        tick(GAP - 1);
        chk("R4 last gap cycle", OFF, 4'hF);
        tick(1);
        chk("R4 make edge", RING, 4'hF);

        // R12 zc during ring ignored
        @(negedge clk); zc = 1'b1;
        tick(1); zc = 1'b0;
        chk("R12 zc in ring", RING, 4'hF);

        // R12 R13 timeout release
        set_mode(1'b0);
        chk("R12 acc lingers", 4'b0001, 4'hF);
        tick(GAP);
        chk("R13 overlap", 4'b1101, 4'hF);
        tick(TMO - GAP - 1);
        chk("R12 last acc cycle", 4'b1101, 4'hF);
        tick(1);
        chk("R12 timeout release", IDLE, 4'hF);

        // R12 zc release
        set_mode(1'b1);
        tick(SETTLE);
        set_mode(1'b0);
        tick(GAP);
        chk("R13 overlap zc case", 4'b1101, 4'hF);
        @(negedge clk); zc = 1'b1;
        tick(1); zc = 1'b0;
        chk("R12 zc release", IDLE, 4'hF);

        // R5 R6 hold
        @(negedge clk); hold = 1'b1;
        tick(1);
        set_mode(1'b1);
        tick(5);
        chk("R5 held idle", IDLE, 4'hF);
        @(negedge clk); hold = 1'b0;
        tick(1);
        chk("R6 release break", OFF, 4'hF);
        tick(GAP);
        chk("R6 release make", RING, 4'hF);

        // R7 pin low while held in ring
        @(negedge clk); hold = 1'b1;
        tick(2);
        @(negedge clk); ext_low = 1'b1;
        tick(1);
        chk("R7 pin low overrides hold", OFF, 4'b1110);
        @(negedge clk); ext_low = 1'b0; hold = 1'b0; mode = 1'b0;
        tick(SETTLE);

        // R8 R9 thermal
        temp_strobe(10'sd150);
        chk_pull("R8 equal no trip", 1'b0);
        tick(1);
        chk("R8 equal no trip", IDLE, 4'hF);
        @(negedge clk); tcode = 10'sd200; tvld = 1'b0;
        tick(2);
        chk_pull("R9 no strobe ignored", 1'b0);
        temp_strobe(10'sd151);
        chk_pull("R8 trip pull", 1'b1);
        chk("R8 trip edge", IDLE, 4'hF);
        tick(1);
        chk("R8 all off", OFF, 4'hF);
        temp_strobe(10'sd138);
        chk_pull("R9 inside band", 1'b1);
        tick(3);
        chk("R9 inside band", OFF, 4'hF);
        temp_strobe(10'sd137);
        chk_pull("R9 release", 1'b0);
        tick(GAP);
        chk("R9 release gap", OFF, 4'hF);
        tick(1);
        chk("R9 release make", IDLE, 4'hF);

        // R10 external pull-up
        @(negedge clk); force_hi = 1'b1;
        temp_strobe(10'sd160);
        chk_pull("R10 pull", 1'b1);
        tick(1);
        chk("R10 forced high still off", OFF, 4'hF);
        temp_strobe(10'sd100);
        tick(SETTLE);
        @(negedge clk); force_hi = 1'b0;
        tick(1);
        chk("R10 recovered", IDLE, 4'hF);

        // R11 battery
        vbat_strobe(-10'sd10);
        tick(2);
        chk("R11 equal no trip", IDLE, 4'hF);
        vbat_strobe(-10'sd9);
        chk("R11 trip edge", IDLE, 4'hF);
        tick(1);
        chk("R11 all off", OFF, 4'hF);
        vbat_strobe(-10'sd15);
        tick(3);
        chk("R11 inside band", OFF, 4'hF);
        vbat_strobe(-10'sd16);
        tick(GAP);
        chk("R11 release gap", OFF, 4'hF);
        tick(1);
        chk("R11 release make", IDLE, 4'hF);
        vbat_strobe(10'sd0);
        tick(1);
        chk("R11 missing battery", OFF, 4'hF);
        vbat_strobe(-10'sd48);
        tick(SETTLE);
        chk("R11 restored", IDLE, 4'hF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule